// File: doc/BRIEF.md
# Configurable Asynchronous Serial Frame Transmitter

This block turns parallel bytes into asynchronous serial frames on a single line. A five-bit format control word sets the character shape: 5 to 8 data bits, an optional parity bit of selectable sense, and one, one and a half or two stop bits. A byte is offered on a valid/ready handshake. It is accepted only while the transmitter is idle.

Frame timing comes from a baud tick supplied from outside at sixteen times the bit rate. Every bit period is counted in sixteenths, so a half stop bit is exact. Each frame has a low start bit, then the data bits least significant first, then the parity bit if enabled, then the high stop period.

The format and the data are both captured when a frame is accepted. After that, changes on the control word or the data input affect only later frames.

Top module: `serial_frame_tx`

## Requirements
- R1: After reset, `tx_out` is high, `in_ready` is high and `tx_busy` is low.
- R2: `line_ctrl[1:0]` sets the number of data bits: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Only that many low-order bits of `in_data` are sent.
- R3: The stop period is high. With `line_ctrl[2]`=0 it lasts 16 ticks. With `line_ctrl[2]`=1 it lasts 32 ticks, except with 5-bit characters, where it lasts 24 ticks.
- R4: With `line_ctrl[3]`=1, one parity bit of 16 ticks follows the data bits. With `line_ctrl[3]`=0, the stop period follows the last data bit directly.
- R5: With `line_ctrl[4]`=1 the parity is even: the data bits sent plus the parity bit hold an even number of ones. With `line_ctrl[4]`=0 the parity is odd.
- R6: A frame starts with a low start bit of 16 ticks. The data bits follow, least significant first, each held for 16 ticks. `tx_out` changes only on clock edges where `baud_tick` is high.
- R7: The format and the data are captured on the accepting edge. Changes on `line_ctrl` or `in_data` during a frame do not alter that frame.
- R8: `in_ready` is high only while idle, and `in_valid` has no effect while busy. `tx_busy` goes high on the accepting edge and stays high through the last stop tick.
- R9: On the edge that completes the last stop tick, the block returns to idle: `tx_busy` low, `in_ready` high, `tx_out` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| baud_tick | input | 1 | Single-cycle pulse at 16x the bit rate |
| line_ctrl | input | 5 | Format: [1:0] data length, [2] stop select, [3] parity enable, [4] even parity |
| in_data | input | 8 | Byte to send |
| in_valid | input | 1 | Byte on `in_data` is offered |
| in_ready | output | 1 | Transmitter idle, offer will be accepted |
| tx_out | output | 1 | Serial line, idle high |
| tx_busy | output | 1 | Frame in progress |

## Verification
The assertions rely on `baud_tick`, `in_valid`, `line_ctrl` and `in_data` being driven to known values away from the clock edge, and on `in_valid` being held through the accepting edge. The bench changes every input on the falling clock edge and never leaves one undriven. It pulses `baud_tick` on every second cycle, so tick edges and non-tick edges both occur in every bit period. While a frame is running, it holds `in_valid` high and inverts both the data and the control word, to exercise R7 and R8 within these assumptions.

// File: rtl/sft_pkg.sv
package sft_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } sft_state_e;

  typedef enum logic [1:0] {
    STOP_ONE,
    STOP_ONE_HALF,
    STOP_TWO
  } sft_stop_e;

  typedef struct packed {
    logic [3:0] nbits;
    logic       par_en;
    logic       par_val;
    sft_stop_e  stop_sel;
  } sft_fmt_t;

endpackage

// File: rtl/sft_fmt_decode.sv
module sft_fmt_decode
  import sft_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [4:0]        ctrl,
  input  logic [DATA_W-1:0] data,
  output sft_fmt_t          fmt
);

  logic [DATA_W-1:0] mask;
  logic [3:0]        nbits;

  always_comb begin
    nbits = 4'd5 + {2'b00, ctrl[1:0]};
    mask  = '0;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < int'(nbits)) mask[i] = 1'b1;
    end
  end

  always_comb begin
    fmt.nbits  = nbits;
    fmt.par_en = ctrl[3];
    // even parity: bit equals XOR of data; odd: its inverse
    fmt.par_val = ctrl[4] ? ^(data & mask) : ~^(data & mask);
    if (!ctrl[2])              fmt.stop_sel = STOP_ONE;
    else if (ctrl[1:0] == 2'b00) fmt.stop_sel = STOP_ONE_HALF;
    else                       fmt.stop_sel = STOP_TWO;
  end

endmodule

// File: rtl/sft_bit_timer.sv
module sft_bit_timer #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [CNT_W-1:0] last_cnt,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign done   = tick && (cnt_q == last_cnt);
  assign cnt_en = clr || tick;

  always_comb begin
    if (clr || done) cnt_d = '0;
    else             cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= last_cnt || $past(clr) || !$past(rst_n));

endmodule

// File: rtl/serial_frame_tx.sv
module serial_frame_tx
  import sft_pkg::*;
#(
  parameter int unsigned OVS    = 16,
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              baud_tick,
  input  logic [4:0]        line_ctrl,
  input  logic [DATA_W-1:0] in_data,
  input  logic              in_valid,
  output logic              in_ready,
  output logic              tx_out,
  output logic              tx_busy
);

  localparam int unsigned CNT_W    = $clog2(2 * OVS);
  localparam int unsigned IDX_W    = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] LAST_BIT  = CNT_W'(OVS - 1);
  localparam logic [CNT_W-1:0] LAST_S1   = CNT_W'(OVS - 1);
  localparam logic [CNT_W-1:0] LAST_S1P5 = CNT_W'(OVS + OVS / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_S2   = CNT_W'(2 * OVS - 1);

  sft_state_e        state_q, state_d;
  sft_fmt_t          fmt_q, fmt_new;
  logic [DATA_W-1:0] shreg_q, shreg_d;
  logic [IDX_W-1:0]  bidx_q, bidx_d;
  logic              accept, bit_done, last_data;
  logic [CNT_W-1:0]  last_cnt;
  logic              dp_en;

  sft_fmt_decode #(.DATA_W(DATA_W)) u_dec (
    .ctrl (line_ctrl),
    .data (in_data),
    .fmt  (fmt_new)
  );

  always_comb begin
    if (state_q == ST_STOP) begin
      case (fmt_q.stop_sel)
        STOP_ONE_HALF: last_cnt = LAST_S1P5;
        STOP_TWO:      last_cnt = LAST_S2;
        default:       last_cnt = LAST_S1;
      endcase
    end else begin
      last_cnt = LAST_BIT;
    end
  end

  sft_bit_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (accept),
    .tick     (baud_tick),
    .last_cnt (last_cnt),
    .done     (bit_done)
  );

  assign in_ready  = (state_q == ST_IDLE);
  assign accept    = in_ready && in_valid;
  assign last_data = ({{(4-IDX_W){1'b0}}, bidx_q} == fmt_q.nbits - 4'd1);

  // next state
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE:   if (accept)   state_d = ST_START;
      ST_START:  if (bit_done) state_d = ST_DATA;
      ST_DATA:   if (bit_done && last_data)
                   state_d = fmt_q.par_en ? ST_PARITY : ST_STOP;
      ST_PARITY: if (bit_done) state_d = ST_STOP;
      ST_STOP:   if (bit_done) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  // datapath next values
  always_comb begin
    shreg_d = shreg_q;
    bidx_d  = bidx_q;
    if (accept) begin
      shreg_d = in_data;
      bidx_d  = '0;
    end else if (state_q == ST_DATA && bit_done) begin
      shreg_d = shreg_q >> 1;
      bidx_d  = bidx_q + 1'b1;
    end
  end

  assign dp_en = accept || (state_q == ST_DATA && bit_done);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      fmt_q <= '0;
    else if (accept) fmt_q <= fmt_new;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg_q <= '0;
      bidx_q  <= '0;
    end else if (dp_en) begin
      shreg_q <= shreg_d;
      bidx_q  <= bidx_d;
    end
  end

  always_comb begin
    case (state_q)
      ST_START:  tx_out = 1'b0;
      ST_DATA:   tx_out = shreg_q[0];
      ST_PARITY: tx_out = fmt_q.par_val;
      default:   tx_out = 1'b1;
    endcase
  end

  assign tx_busy = (state_q != ST_IDLE);

  assert_busy_needs_offer_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> $past(in_valid));

  assert_start_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> !tx_out);

  assert_line_moves_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && $past(tx_busy) && !$past(baud_tick)) |-> $stable(tx_out));

  assert_fmt_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_busy && $past(tx_busy)) |-> $stable(fmt_q));

  assert_ends_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_busy) |-> ($past(tx_out) && $past(baud_tick)));

  assert_idle_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> (tx_out && in_ready));

endmodule

// File: tb/serial_frame_tx_tb.sv
module serial_frame_tx_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk;
  logic       rst_n;
  logic       baud_tick;
  logic [4:0] line_ctrl;
  logic [7:0] in_data;
  logic       in_valid;
  logic       in_ready;
  logic       tx_out;
  logic       tx_busy;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  serial_frame_tx dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .baud_tick (baud_tick),
    .line_ctrl (line_ctrl),
    .in_data   (in_data),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .tx_out    (tx_out),
    .tx_busy   (tx_busy)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic exp_line(input int t, input logic [4:0] c,
                                    input logic [7:0] d);
    int   nb;
    logic p;
    int   ones;
    nb = 5 + int'(c[1:0]);
    ones = 0;
    for (int i = 0; i < nb; i++) ones += int'(d[i]);
    p = c[4] ? logic'(ones % 2) : ~logic'(ones % 2);
    if (t < 16) return 1'b0;
    if (t < 16 + 16 * nb) return d[(t - 16) / 16];
    if (c[3] && t < 32 + 16 * nb) return p;
    return 1'b1;
  endfunction

  function automatic string seg_req(input int t, input logic [4:0] c);
    int nb;
    nb = 5 + int'(c[1:0]);
    if (t < 16) return "R6";
    if (t < 16 + 16 * nb) return "R2";
    if (c[3] && t < 32 + 16 * nb) return (c[4] ? "R5" : "R4");
    return "R3";
  endfunction

  task automatic send_frame(input logic [4:0] c, input logic [7:0] d);
    int nb, stop_t, total;
    nb     = 5 + int'(c[1:0]);
    stop_t = !c[2] ? 16 : (c[1:0] == 2'b00 ? 24 : 32);
    total  = 16 + 16 * nb + (c[3] ? 16 : 0) + stop_t;
    @(negedge clk);
    baud_tick = 1'b0;
    line_ctrl = c;
    in_data   = d;
    in_valid  = 1'b1;
    check("R8", "ready before offer", in_ready, 1'b1);
    @(negedge clk);
    // R7: disturb format and data while the frame runs; R8: offer held while busy
    line_ctrl = ~c;
    in_data   = ~d;
    check("R8", "busy after accept", tx_busy, 1'b1);
    check("R8", "ready while busy", in_ready, 1'b0);
    for (int t = 0; t < total; t++) begin
      @(negedge clk);
      baud_tick = 1'b0;
      if (t == total - 2) in_valid = 1'b0;
      @(negedge clk);
      check(seg_req(t, c), $sformatf("line ctrl=%h data=%h tick=%0d", c, d, t),
            tx_out, exp_line(t, c, d));
      if (t == total - 1) check("R8", "busy on last stop tick", tx_busy, 1'b1);
      baud_tick = 1'b1;
    end
    @(negedge clk);
    baud_tick = 1'b0;
    check("R9", "busy after frame", tx_busy, 1'b0);
    check("R9", "ready after frame", in_ready, 1'b1);
    check("R9", "line after frame", tx_out, 1'b1);
  endtask

  initial begin
    for (int cyc = 0; cyc < WATCHDOG; cyc++) begin
      @(posedge clk);
      if (finished) break;
    end
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n     = 1'b0;
    baud_tick = 1'b0;
    line_ctrl = '0;
    in_data   = '0;
    in_valid  = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", "reset line", tx_out, 1'b1);
    check("R1", "reset ready", in_ready, 1'b1);
    check("R1", "reset busy", tx_busy, 1'b0);
    rst_n = 1'b1;
    // R6: ticks while idle do nothing
    repeat (4) begin
      @(negedge clk);
      baud_tick = ~baud_tick;
    end
    @(negedge clk);
    baud_tick = 1'b0;
    check("R1", "idle line after ticks", tx_out, 1'b1);
    check("R1", "idle busy after ticks", tx_busy, 1'b0);
    for (int c = 0; c < 32; c++) begin
      for (int k = 0; k < 3; k++) begin
        logic [7:0] d;
        d = (k == 0) ? 8'h00 : (k == 1) ? 8'hFF : (8'(c * 37) ^ 8'h5A);
        send_frame(5'(c), d);
      end
    end
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule